// File: doc/BRIEF.md
# Iterative Divide and Modulo Unit

This block computes the quotient or the remainder of two integers for the arithmetic classes of a 64-bit instruction set. A caller presents the instruction byte, the 16-bit offset field, the immediate, the destination register value and the source register value, then pulses `start`. The unit holds `busy` while it works and pulses `done` for one cycle. The answer appears on `result` in that same cycle and stays there until the next operation completes. The algorithm is radix-2 restoring division and produces one quotient bit per clock. Signed operations divide the magnitudes and then fix the signs of the quotient and remainder.

The instruction byte is split into three fields: an operation code in bits 7..4, an operand-source bit in bit 3 and a class in bits 2..0. The class picks a full-width or a half-width operation. In a half-width operation only the low half of each operand takes part, and the upper half of the result is cleared. A zero divisor never traps. It is detected when the operation is accepted and gives its defined value on the next cycle, without running the iterations.

The controller has four states. IDLE waits for `start`. ITER runs one shift-subtract step per cycle. SIGN applies the sign correction and the width shaping to the result. DONE raises `done` for one cycle. The transitions are:
- IDLE to ITER on an accepted start with a non-zero divisor.
- IDLE to DONE on an accepted start with a zero divisor.
- ITER to ITER while steps remain.
- ITER to SIGN after the last step.
- SIGN to DONE, unconditionally.
- DONE to IDLE, unconditionally.

Top module: `divmod_unit`

## Requirements
- R1: Decoding of the inputs.
  - An operation code of 0x3 in `opcode[7:4]` selects divide, and 0x9 selects modulo.
  - `opcode[3]`=1 takes the divisor from `src_val`; 0 takes it from `imm`.
  - `opcode[2:0]`=3'b111 selects full width; 3'b100 selects half width.
  - `offset`=1 selects signed operation; `offset`=0 selects unsigned operation.
- R2: A full-width unsigned operation returns `dst_val / divisor` or `dst_val % divisor` as DATA_W-bit unsigned values.
- R3: A half-width operation uses only `dst_val[HALF_W-1:0]` and the low half of the divisor. It treats an immediate as an unsigned HALF_W-bit value, and `result[DATA_W-1:HALF_W]` is always zero.
- R4: Signed division truncates toward zero. A signed remainder takes the sign of the dividend, at the width of the operation.
- R5: In a full-width operation the immediate is first sign-extended to DATA_W bits, and then treated as signed or unsigned according to `offset`.
- R6: A divide by a zero divisor gives a result of 0, at either width.
- R7: A full-width modulo by a zero divisor returns `dst_val` unchanged.
- R8: A half-width modulo by a zero divisor returns `dst_val[HALF_W-1:0]` with the upper half cleared.
- R9: The most negative value divided by minus one gives the most negative value as the quotient and 0 as the remainder, at the width of the operation.
- R10: Call the clock edge that accepts `start` edge 0.
  - With a zero divisor, `done` is high in the cycle after edge 0.
  - Otherwise, with W = DATA_W or HALF_W steps, `done` is high in the cycle after edge W+1.
- R11: After reset `busy`, `done` and `result` are 0. `busy` is high from the accepted start until the cycle before `done`. `done` lasts exactly one cycle and is never high together with `busy`.
- R12: `start` is accepted only in IDLE. A start pulse raised while `busy` or `done` is high changes neither the timing nor the result of the operation in progress, and starts nothing.
- R13: `result` changes only on the edge that raises `done`, and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an operation (only in IDLE) |
| opcode | input | 8 | Operation code, operand source and class |
| offset | input | 16 | 1 selects signed, 0 selects unsigned |
| imm | input | DATA_W/2 | Immediate divisor |
| dst_val | input | DATA_W | Dividend, the destination register value |
| src_val | input | DATA_W | Register divisor |
| result | output | DATA_W | Quotient or remainder, held between completions |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with DATA_W=16, so a half-width operation works on 8-bit operands.

At that size the bench can afford the following in all eight combinations of divide or modulo, signed or unsigned, and half or full width:
- All 256 immediates.
- A dense cross of boundary register values. These include 0x80, 0xFF, 0x8000 and 0xFFFF, the values that make the most-negative-divided-by-minus-one cases and the zero-divisor cases.

Upper operand bits that are set but ignored in half-width mode are part of these sweeps. The iteration counts of 8 and 16 keep the exact latency checks for both widths inside the cycle budget.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_SIGN = 2'd2,
        ST_DONE = 2'd3
    } dm_state_e;

    // Field values of the instruction byte
    localparam logic [3:0]  CODE_DIV   = 4'h3;
    localparam logic [3:0]  CODE_MOD   = 4'h9;
    localparam logic [2:0]  CLASS_WIDE = 3'b111;
    localparam logic [2:0]  CLASS_HALF = 3'b100;
    localparam logic [15:0] OFF_SIGNED = 16'd1;

    // Per-operation control captured when an operation is accepted
    typedef struct packed {
        logic is_mod;
        logic wide;
        logic neg_q;
        logic neg_r;
    } dm_ctl_t;

endpackage

// File: rtl/divmod_decode.sv
module divmod_decode
    import divmod_pkg::*;
#(
    parameter  int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [7:0]        opcode,
    input  logic [15:0]       offset,
    input  logic [HALF_W-1:0] imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output dm_ctl_t           ctl,
    output logic [DATA_W-1:0] mag_a,
    output logic [DATA_W-1:0] mag_b,
    output logic              div_zero,
    output logic [DATA_W-1:0] zero_res
);

    logic              wide;
    logic              use_reg;
    logic              is_mod;
    logic              is_signed;
    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] b_full;
    logic [HALF_W-1:0] a_half;
    logic [HALF_W-1:0] b_half;
    logic [HALF_W-1:0] a_half_neg;
    logic [HALF_W-1:0] b_half_neg;
    logic [DATA_W-1:0] a_ext;
    logic [DATA_W-1:0] b_ext;
    logic              sa;
    logic              sb;

    always_comb begin
        wide      = (opcode[2:0] == CLASS_WIDE);
        use_reg   = opcode[3];
        is_mod    = (opcode[7:4] == CODE_MOD);
        is_signed = (offset == OFF_SIGNED);

        // The immediate widens with its sign for full-width operations
        imm_sx = {{HALF_W{imm[HALF_W-1]}}, imm};
        b_full = use_reg ? src_val : imm_sx;
        a_half = dst_val[HALF_W-1:0];
        b_half = use_reg ? src_val[HALF_W-1:0] : imm;

        a_half_neg = '0 - a_half;
        b_half_neg = '0 - b_half;

        a_ext = wide ? dst_val : {{HALF_W{1'b0}}, a_half};
        b_ext = wide ? b_full  : {{HALF_W{1'b0}}, b_half};

        sa = is_signed & (wide ? dst_val[DATA_W-1] : a_half[HALF_W-1]);
        sb = is_signed & (wide ? b_full[DATA_W-1]  : b_half[HALF_W-1]);

        if (sa) begin
            mag_a = wide ? ('0 - dst_val) : {{HALF_W{1'b0}}, a_half_neg};
        end else begin
            mag_a = a_ext;
        end
        if (sb) begin
            mag_b = wide ? ('0 - b_full) : {{HALF_W{1'b0}}, b_half_neg};
        end else begin
            mag_b = b_ext;
        end

        div_zero = (b_ext == '0);
        // Zero divisor: quotient 0, remainder is the width-shaped dividend
        zero_res = is_mod ? a_ext : '0;

        ctl.is_mod = is_mod;
        ctl.wide   = wide;
        ctl.neg_q  = sa ^ sb;
        ctl.neg_r  = sa;
    end

endmodule

// File: rtl/divmod_core.sv
module divmod_core #(
    parameter  int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              wide,
    input  logic [DATA_W-1:0] mag_a,
    input  logic [DATA_W-1:0] mag_b,
    output logic [DATA_W-1:0] quo,
    output logic [DATA_W-1:0] rem
);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] shq_q;
    logic [DATA_W-1:0] dvs_q;
    logic [DATA_W-1:0] low;
    logic [DATA_W-1:0] diff;
    logic              fits;

    // Partial remainder shifted left by one with the next dividend bit.
    // A set top bit means the shifted value exceeds any divisor.
    always_comb begin
        low  = {acc_q[DATA_W-2:0], shq_q[DATA_W-1]};
        fits = acc_q[DATA_W-1] | (low >= dvs_q);
        diff = low - dvs_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            shq_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            // Half-width dividends are left-aligned so one shift path serves both
            shq_q <= wide ? mag_a : {mag_a[HALF_W-1:0], {HALF_W{1'b0}}};
            dvs_q <= mag_b;
        end else if (step) begin
            acc_q <= fits ? diff : low;
            shq_q <= {shq_q[DATA_W-2:0], fits};
        end
    end

    assign quo = shq_q;
    assign rem = acc_q;

endmodule

// File: rtl/divmod_ctrl.sv
module divmod_ctrl
    import divmod_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic div_zero,
    input  logic wide,
    output logic load,
    output logic step,
    output logic cap_calc,
    output logic busy,
    output logic done
);

    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    dm_state_e        state_q;
    dm_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remaining iteration count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= wide ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = div_zero ? ST_DONE : ST_ITER;
                end
            end
            ST_ITER: begin
                if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_SIGN;
                end
            end
            ST_SIGN: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        cap_calc = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_ITER: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_SIGN: begin
                cap_calc = 1'b1;
                busy     = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/divmod_post.sv
module divmod_post
    import divmod_pkg::*;
#(
    parameter  int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_zero,
    input  logic              cap_calc,
    input  dm_ctl_t           ctl,
    input  logic [DATA_W-1:0] quo,
    input  logic [DATA_W-1:0] rem,
    input  logic [DATA_W-1:0] zero_res,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] fixed;
    logic [DATA_W-1:0] shaped;
    logic              neg;

    always_comb begin
        sel    = ctl.is_mod ? rem : quo;
        neg    = ctl.is_mod ? ctl.neg_r : ctl.neg_q;
        fixed  = neg ? ('0 - sel) : sel;
        shaped = ctl.wide ? fixed : {{HALF_W{1'b0}}, fixed[HALF_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (cap_zero) begin
            result <= zero_res;
        end else if (cap_calc) begin
            result <= shaped;
        end
    end

endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
    import divmod_pkg::*;
#(
    parameter  int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [15:0]       offset,
    input  logic [HALF_W-1:0] imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] result,
    output logic              busy,
    output logic              done
);

    dm_ctl_t           ctl_d;
    dm_ctl_t           ctl_q;
    logic [DATA_W-1:0] mag_a;
    logic [DATA_W-1:0] mag_b;
    logic [DATA_W-1:0] zero_res;
    logic [DATA_W-1:0] quo;
    logic [DATA_W-1:0] rem;
    logic              div_zero;
    logic              load;
    logic              step;
    logic              cap_calc;

    divmod_decode #(.DATA_W(DATA_W)) u_decode (
        .opcode   (opcode),
        .offset   (offset),
        .imm      (imm),
        .dst_val  (dst_val),
        .src_val  (src_val),
        .ctl      (ctl_d),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .div_zero (div_zero),
        .zero_res (zero_res)
    );

    divmod_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .div_zero (div_zero),
        .wide     (ctl_d.wide),
        .load     (load),
        .step     (step),
        .cap_calc (cap_calc),
        .busy     (busy),
        .done     (done)
    );

    // Operation control held for the sign-correction state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (load) begin
            ctl_q <= ctl_d;
        end
    end

    divmod_core #(.DATA_W(DATA_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .wide  (ctl_d.wide),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    divmod_post #(.DATA_W(DATA_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_zero (load & div_zero),
        .cap_calc (cap_calc),
        .ctl      (ctl_q),
        .quo      (quo),
        .rem      (rem),
        .zero_res (zero_res),
        .result   (result)
    );

endmodule

// File: rtl/divmod_unit_chk.sv
module divmod_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        cls,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result
);

    localparam int HALF_W = DATA_W / 2;
    localparam int RUN_W  = $clog2(DATA_W + 3);

    logic             wide_q;
    logic [RUN_W-1:0] run_q;
    logic             accept;

    assign accept = start && !busy && !done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            run_q  <= '0;
        end else begin
            if (accept) begin
                wide_q <= (cls == 3'b111);
            end
            run_q <= busy ? (run_q + RUN_W'(1)) : '0;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held"); // R11

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)) else $error("busy with done"); // R11

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy || done)) else $error("start not taken"); // R10

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(DATA_W + 1)) else $error("busy too long"); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)) else $error("result moved"); // R13

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (result[DATA_W-1:HALF_W] == '0)) else $error("upper bits set"); // R3

endmodule

bind divmod_unit divmod_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cls    (opcode[2:0]),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/divmod_unit_bench.sv
module divmod_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int HW = DW / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [7:0]    opcode;
    logic [15:0]   offset;
    logic [HW-1:0] imm;
    logic [DW-1:0] dst_val;
    logic [DW-1:0] src_val;
    logic [DW-1:0] result;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    divmod_unit #(.DATA_W(DW)) u_divmod_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opcode  (opcode),
        .offset  (offset),
        .imm     (imm),
        .dst_val (dst_val),
        .src_val (src_val),
        .result  (result),
        .busy    (busy),
        .done    (done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    endtask

    // R1 encoding: code in [7:4], source bit in [3], class in [2:0]
    function automatic logic [7:0] op_byte(input logic is_mod, input logic use_reg, input logic wide);
        return {(is_mod ? 4'h9 : 4'h3), use_reg, (wide ? 3'b111 : 3'b100)};
    endfunction

    function automatic logic [DW-1:0] pick(input int i);
        case (i)
            0: return 16'h0000;   1: return 16'h0001;   2: return 16'h0002;   3: return 16'h0003;
            4: return 16'h0007;   5: return 16'h007F;   6: return 16'h0080;   7: return 16'h0081;
            8: return 16'h00FF;   9: return 16'h7FFF;  10: return 16'h8000;  11: return 16'h8001;
           12: return 16'hFFFE;  13: return 16'hFFFF;  14: return 16'h1234;
            default: return 16'hA5C3;
        endcase
    endfunction

    // Arithmetic reference built from R2..R9
    function automatic logic [DW-1:0] model(input logic is_mod, input logic sgn, input logic wide,
                                            input logic use_reg, input logic [HW-1:0] im,
                                            input logic [DW-1:0] d, input logic [DW-1:0] s);
        longint a, b, q, r, res;
        int w;
        w = wide ? DW : HW;
        if (wide) begin
            a = longint'(d);
            b = use_reg ? longint'(s) : longint'({{HW{im[HW-1]}}, im});
        end else begin
            a = longint'(d[HW-1:0]);
            b = use_reg ? longint'(s[HW-1:0]) : longint'(im);
        end
        if (b == 0) return is_mod ? DW'(a) : '0;
        if (sgn) begin
            if (a[w-1]) a = a - (longint'(1) << w);
            if (b[w-1]) b = b - (longint'(1) << w);
        end
        q = a / b;
        r = a % b;
        res = is_mod ? r : q;
        res = res & ((longint'(1) << w) - 1);
        return DW'(res);
    endfunction

    task automatic run_op(input logic is_mod, input logic sgn, input logic wide, input logic use_reg,
                          input logic [HW-1:0] im, input logic [DW-1:0] d, input logic [DW-1:0] s);
        logic [DW-1:0] exp;
        logic [DW-1:0] bw;
        logic [DW-1:0] aw;
        logic [DW-1:0] allone;
        logic [DW-1:0] minv;
        logic          zb;
        int            k;
        int            exp_lat;
        bit            busy_ok;
        string         tag;
        exp = model(is_mod, sgn, wide, use_reg, im, d, s);
        if (wide) begin
            aw = d;
            bw = use_reg ? s : {{HW{im[HW-1]}}, im};
            allone = '1;
            minv = 16'h8000;
        end else begin
            aw = {8'h00, d[HW-1:0]};
            bw = use_reg ? {8'h00, s[HW-1:0]} : {8'h00, im};
            allone = 16'h00FF;
            minv = 16'h0080;
        end
        zb = (bw == '0);
        if (zb) tag = !is_mod ? "R6" : (wide ? "R7" : "R8");
        else if (sgn && aw == minv && bw == allone) tag = "R9";
        else if (sgn) tag = "R4";
        else if (!wide) tag = "R3";
        else if (!use_reg) tag = "R5";
        else tag = "R2";
        if (!use_reg) tag = {tag, " R1 imm"};
        exp_lat = zb ? 1 : ((wide ? DW : HW) + 2);

        @(negedge clk);
        opcode  = op_byte(is_mod, use_reg, wide);
        offset  = sgn ? 16'd1 : 16'd0;
        imm     = im;
        dst_val = d;
        src_val = s;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        k       = 1;
        busy_ok = 1'b1;
        while (!done && k < 200) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            k++;
        end
        if (busy) busy_ok = 1'b0;
        check(tag, result, exp);
        check("R10 latency", k, exp_lat);
        check("R11 busy window", busy_ok, 1);
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        #(CLK_PERIOD * 195000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        int k;
        rst_n   = 1'b0;
        start   = 1'b0;
        opcode  = '0;
        offset  = '0;
        imm     = '0;
        dst_val = '0;
        src_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset busy", busy, 0);
        check("R11 reset done", done, 0);
        check("R11 reset result", result, 0);

        // Register divisors: boundary cross in all eight mode combinations
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    run_op(m[0], m[1], m[2], 1'b1, 8'h00, pick(i), pick(j));
                end
            end
        end

        // Immediate divisors: every 8-bit value, src_val must be ignored (R1)
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 256; v++) begin
                run_op(m[0], m[1], m[2], 1'b0, v[HW-1:0], pick(11), 16'h0000);
                run_op(m[0], m[1], m[2], 1'b0, v[HW-1:0], pick(14), 16'h0005);
            end
        end

        // R12: a start pulse during busy is ignored
        @(negedge clk);
        opcode  = op_byte(1'b0, 1'b1, 1'b1);
        offset  = 16'd0;
        dst_val = 16'hF00D;
        src_val = 16'h0007;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        @(negedge clk); k++;
        @(negedge clk); k++;
        opcode  = op_byte(1'b1, 1'b1, 1'b0);
        dst_val = 16'h0001;
        src_val = 16'h0000;
        start   = 1'b1;
        @(negedge clk); k++;
        start = 1'b0;
        while (!done && k < 200) begin
            @(negedge clk);
            k++;
        end
        check("R12 latency kept", k, DW + 2);
        check("R12 result kept", result, 16'hF00D / 16'h0007);

        // R12: a start pulse in the done cycle starts nothing
        held  = result;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12 no start from done busy", busy, 0);
        check("R12 no start from done done", done, 0);

        // R13: result holds while inputs move
        dst_val = 16'h5555;
        src_val = 16'h0003;
        opcode  = op_byte(1'b1, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        check("R13 result held", result, held);

        summary();
        $finish;
    end

endmodule